// File: doc/BRIEF.md
# RTC interrupt flag register

This block holds the interrupt status of a real-time clock. Three event sources feed it: a divider tap that produces a periodic tick, an alarm-match pulse and an update-complete pulse. Each event is caught in a flag of its own. Events are caught whether or not their source is enabled. The three flags and a summary request bit form a readable status byte. A single read strobe on that byte clears all three flags together.

The summary bit is the OR of each flag ANDed with its enable. The enable bits come from a control register outside this block. The interrupt pin is active low and follows the summary bit. A second status byte carries a supply-valid indication in its top bit.

The status byte is combinational from the flags. A bus read samples it in the strobe cycle, and the clear takes effect at the following clock edge. An event that arrives in the same cycle as the strobe survives the clear.

Top module: `rtc_irq_flags`

## Requirements
- R1: While `rst_ni` is low, all three flags are 0, `status_o` is 0x00 and `irq_no` is 1.
- R2: `status_o` holds the summary bit at bit 7, the periodic flag at bit 6, the alarm flag at bit 5 and the update flag at bit 4. Bits 3..0 always read 0.
- R3: The periodic flag sets at the clock edge that first samples `tap_i` high after it was low, whatever `en_per_i` is. A tap that stays high does not set the flag again.
- R4: The alarm flag sets at the clock edge that samples `alarm_i` high, whatever `en_alm_i` is.
- R5: The update flag sets at the clock edge that samples `update_i` high, whatever `en_upd_i` is.
- R6: `status_o[7]` equals (periodic AND `en_per_i`) OR (alarm AND `en_alm_i`) OR (update AND `en_upd_i`).
- R7: `irq_no` is 0 exactly when `status_o[7]` is 1.
- R8: In a cycle with `rd_status_i` high, `status_o` shows the flags as they were before the clear. All three flags are 0 after the next edge, unless R9 applies.
- R9: An event sampled at the same edge as `rd_status_i` leaves its flag set after that edge.
- R10: A change on an enable input changes `status_o[7]` and `irq_no` in the same cycle. It does not change bits 6..4.
- R11: `aux_status_o[7]` equals `supply_ok_i`, and `aux_status_o[6:0]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tap_i | input | 1 | Selected divider tap level |
| alarm_i | input | 1 | Alarm-match event pulse |
| update_i | input | 1 | Update-complete event pulse |
| en_per_i | input | 1 | Periodic interrupt enable |
| en_alm_i | input | 1 | Alarm interrupt enable |
| en_upd_i | input | 1 | Update interrupt enable |
| rd_status_i | input | 1 | Read strobe for the status byte; clears the flags |
| supply_ok_i | input | 1 | Supply above trip threshold |
| status_o | output | 8 | Status byte: summary, three flags, zero nibble |
| aux_status_o | output | 8 | Second status byte: valid bit at bit 7, rest zero |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The bench builds the block with the package defaults: an eight-bit byte with the flag field based at bit 4. With these defaults the exact bit positions of R2 and R11 can be checked at the ports. Directed cases cover the tap held high across a clear, a read that coincides with a new event, and enable toggles with the flags standing. Random stimulus then mixes event density, enables, read strobes and supply changes, so that the eight combinations of flags and enables come up many times.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_SRC  = 3;
  localparam int FLAG_LSB = 4;
  localparam int SUM_BIT  = BYTE_W - 1;
  localparam int VLD_BIT  = BYTE_W - 1;
  localparam int PAD_W    = FLAG_LSB;

  // source index order sets bit position: FLAG_LSB + index
  typedef enum int {
    SRC_UPD = 0,
    SRC_ALM = 1,
    SRC_PER = 2
  } src_e;

  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/rtc_irq_edge.sv
module rtc_irq_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/rtc_irq_flag.sv
module rtc_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set wins over clear so a coincident event is not lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/rtc_irq_req.sv
module rtc_irq_req
  import rtc_irq_pkg::*;
(
  input  src_vec_t flags_i,
  input  src_vec_t en_i,
  output logic     req_o,
  output logic     irq_no
);
  assign req_o  = |(flags_i & en_i);
  assign irq_no = ~req_o;
endmodule

// File: rtl/rtc_irq_fmt.sv
module rtc_irq_fmt
  import rtc_irq_pkg::*;
(
  input  logic              req_i,
  input  src_vec_t          flags_i,
  input  logic              supply_ok_i,
  output logic [BYTE_W-1:0] status_o,
  output logic [BYTE_W-1:0] aux_status_o
);
  always_comb begin
    status_o = '0;
    status_o[SUM_BIT] = req_i;
    for (int i = 0; i < NUM_SRC; i++) status_o[FLAG_LSB+i] = flags_i[i];
    status_o[PAD_W-1:0] = '0;
  end

  always_comb begin
    aux_status_o = '0;
    aux_status_o[VLD_BIT] = supply_ok_i;
  end
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
  import rtc_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tap_i,
  input  logic              alarm_i,
  input  logic              update_i,
  input  logic              en_per_i,
  input  logic              en_alm_i,
  input  logic              en_upd_i,
  input  logic              rd_status_i,
  input  logic              supply_ok_i,
  output logic [BYTE_W-1:0] status_o,
  output logic [BYTE_W-1:0] aux_status_o,
  output logic              irq_no
);
  src_vec_t set_vec, en_vec, flags;
  logic     tap_rise, req;

  rtc_irq_edge u_tap_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (tap_i),
    .rise_o (tap_rise)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[SRC_PER] = tap_rise;
    set_vec[SRC_ALM] = alarm_i;
    set_vec[SRC_UPD] = update_i;
    en_vec           = '0;
    en_vec[SRC_PER]  = en_per_i;
    en_vec[SRC_ALM]  = en_alm_i;
    en_vec[SRC_UPD]  = en_upd_i;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
    rtc_irq_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_vec[g]),
      .clr_i  (rd_status_i),
      .flag_o (flags[g])
    );
  end

  rtc_irq_req u_req (
    .flags_i (flags),
    .en_i    (en_vec),
    .req_o   (req),
    .irq_no  (irq_no)
  );

  rtc_irq_fmt u_fmt (
    .req_i        (req),
    .flags_i      (flags),
    .supply_ok_i  (supply_ok_i),
    .status_o     (status_o),
    .aux_status_o (aux_status_o)
  );
endmodule

// File: rtl/rtc_irq_flags_chk.sv
module rtc_irq_flags_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tap_i,
  input logic       alarm_i,
  input logic       update_i,
  input logic       en_per_i,
  input logic       en_alm_i,
  input logic       en_upd_i,
  input logic       rd_status_i,
  input logic       supply_ok_i,
  input logic [7:0] status_o,
  input logic [7:0] aux_status_o,
  input logic       irq_no
);
  a_r2_low_nibble_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[3:0] == 4'h0);

  a_r4_alarm_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_i |=> status_o[5]);

  a_r5_update_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> status_o[4]);

  a_r6_summary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7] == ((status_o[6] & en_per_i) | (status_o[5] & en_alm_i) |
                    (status_o[4] & en_upd_i)));

  a_r7_pin_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_no == !status_o[7]);

  a_r8_read_clears_alarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_status_i && !alarm_i) |=> !status_o[5]);

  a_r8_read_clears_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_status_i && !update_i) |=> !status_o[4]);

  a_r10_alarm_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_status_i && !alarm_i) |=> status_o[5] == $past(status_o[5]));

  a_r11_aux_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_status_o[6:0] == 7'h00) && (aux_status_o[7] == supply_ok_i));

  logic unused_ok;
  assign unused_ok = tap_i;
endmodule

bind rtc_irq_flags rtc_irq_flags_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tap_i        (tap_i),
  .alarm_i      (alarm_i),
  .update_i     (update_i),
  .en_per_i     (en_per_i),
  .en_alm_i     (en_alm_i),
  .en_upd_i     (en_upd_i),
  .rd_status_i  (rd_status_i),
  .supply_ok_i  (supply_ok_i),
  .status_o     (status_o),
  .aux_status_o (aux_status_o),
  .irq_no       (irq_no)
);

// File: tb/rtc_irq_flags_tb_top.sv
module rtc_irq_flags_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 4000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n, tap, alm, upd, en_p, en_a, en_u, rd, sup;
  logic [7:0] status, aux;
  logic irq_n;

  int nvec = 0;
  int nerr = 0;

  // reference state
  logic m_per = 0, m_alm = 0, m_upd = 0, m_tapq = 0;

  rtc_irq_flags dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tap_i(tap), .alarm_i(alm), .update_i(upd),
    .en_per_i(en_p), .en_alm_i(en_a), .en_upd_i(en_u), .rd_status_i(rd),
    .supply_ok_i(sup), .status_o(status), .aux_status_o(aux), .irq_no(irq_n)
  );

  function automatic logic [7:0] exp_status(logic p, logic a, logic u,
                                            logic ep, logic ea, logic eu);
    logic s;
    s = (p & ep) | (a & ea) | (u & eu);
    return {s, p, a, u, 4'h0};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic check_model(string req);
    logic [7:0] e;
    e = exp_status(m_per, m_alm, m_upd, en_p, en_a, en_u);
    check({req, " status"}, status, e);
    check({req, " irq"}, {7'h0, irq_n}, {7'h0, ~e[7]});
    check({req, " aux"}, aux, {sup, 7'h00});
  endtask

  // one clock: model tracks the flags, ends at the falling edge
  task automatic step();
    logic rise;
    @(posedge clk);
    rise   = tap & ~m_tapq;
    m_per  = rise | (m_per & ~rd);
    m_alm  = alm  | (m_alm & ~rd);
    m_upd  = upd  | (m_upd & ~rd);
    m_tapq = tap;
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    tap = 0; alm = 0; upd = 0; rd = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    rst_n = 0; idle_inputs(); en_p = 1; en_a = 1; en_u = 1; sup = 0;
    alm = 1; upd = 1;
    repeat (3) @(negedge clk);
    check("R1 reset status", status, 8'h00);
    check("R1 reset irq", {7'h0, irq_n}, 8'h01);
    idle_inputs(); en_p = 0; en_a = 0; en_u = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R4: alarm latches with enable off
    alm = 1; step(); alm = 0;
    check("R4 alarm latched disabled", status, 8'h20);
    check("R7 pin idle", {7'h0, irq_n}, 8'h01);

    // R10: enable raises summary at once, flags unchanged
    en_a = 1; #1;
    check("R10 enable on", status, 8'hA0);
    check("R7 pin active", {7'h0, irq_n}, 8'h00);
    en_a = 0; #1;
    check("R10 enable off", status, 8'h20);
    en_a = 1; #1;

    // R8: read shows pre-clear value, then clears
    rd = 1; #1;
    check("R8 pre-clear view", status, 8'hA0);
    step(); rd = 0;
    check("R8 cleared", status, 8'h00);
    check("R8 pin released", {7'h0, irq_n}, 8'h01);

    // R3: tap rising edge, held high does not re-set
    tap = 1; step();
    check("R3 periodic set", status, 8'h40);
    rd = 1; step(); rd = 0;
    check("R3 held tap no reset", status, 8'h00);
    step();
    check("R3 held tap still clear", status, 8'h00);
    tap = 0; step();

    // R5 and R9: update with enable, then coincident read and event
    en_u = 1; upd = 1; step(); upd = 0;
    check("R5 update set", status, 8'h90);
    alm = 1; step(); alm = 0;
    check("R4 alarm set", status, 8'hB0);
    upd = 1; rd = 1; step(); upd = 0; rd = 0;
    check("R9 coincident update kept", status, 8'h90);
    rd = 1; step(); rd = 0;
    check("R8 second clear", status, 8'h00);

    // R11: valid bit
    sup = 1; #1;
    check("R11 valid high", aux, 8'h80);
    sup = 0; #1;
    check("R11 valid low", aux, 8'h00);
    check_model("R2 directed end");

    // random phase
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < N_RAND; i++) begin
      int dens;
      dens = (i / 500) % 4;
      tap  = ($urandom_range(3, 0) < 2) ? ~tap : tap;
      alm  = ($urandom_range(7, 0) <= dens);
      upd  = ($urandom_range(7, 0) <= dens);
      rd   = ($urandom_range(5, 0) == 0);
      en_p = $urandom_range(1, 0);
      en_a = $urandom_range(1, 0);
      en_u = $urandom_range(1, 0);
      sup  = $urandom_range(1, 0);
      #1;
      check_model("R6/R7/R10/R11 pre-edge");
      step();
      check_model("R3/R4/R5/R8/R9 post-edge");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule